// File: doc/BRIEF.md
# External DMA Request Handshake Controller

This block sits between external requesting devices and the per-channel transfer engines of an eight-channel DMA controller. In bus-sharing mode, an external device asks for the data bus on a bus-request pin. The block grants the bus by pulsing a bus-available output. It then opens a fixed window and watches for a transfer-request strobe exactly two cycles after the grant. If the strobe arrives in that cycle, the block latches a transfer descriptor from the data bus and passes it to the channel logic with a one-cycle valid pulse.

Outside the window, the same two pins are decoded as requests. A transfer request alone is a general DMA request. Both pins raised in the same cycle form a direct request to channel 2. With bus sharing off, the bus-request pin and the transfer-request pin act as plain request lines for channels 0 and 1.

In the other direction, the engines report which channel they are servicing. The block answers with an acknowledge strobe and the channel number. The low bits of the channel number go out on dedicated pins. The top bit shares one output pin with bus-available. A grant therefore always takes the pin, and an acknowledge that would land on a grant cycle is pushed back by one cycle.

Top module: `xdma_handshake`

## Requirements
- R1: While reset is active, and in the first cycle after it, the following are all low: `bavl_id2_o`, `strobe_o`, `chan_id_o`, `gen_req_o`, `chan_req_o` and `desc_valid_o`. `desc_o` is zero. Reset returns a partly received grant window to idle.
- R2: In shared mode (`shared_mode_i`=1) with no window open, `bus_req_i`=1 together with `xfer_req_i`=0 starts a grant. `bavl_id2_o` is then high for exactly the one cycle after the request cycle.
- R3: If `xfer_req_i` is high in the cycle two cycles after the grant cycle (the sample cycle), `bus_data_i` of that cycle appears on `desc_o` in the next cycle, and `desc_valid_o` is high for that one cycle only.
- R4: If `xfer_req_i` is low in the sample cycle, no descriptor is taken and `desc_o` keeps its value. In shared mode, request inputs during the grant cycle and the following cycle produce no request pulses and no new grant.
- R5: In shared mode with no window open, `xfer_req_i`=1 with `bus_req_i`=0 gives a one-cycle `gen_req_o` pulse in the next cycle.
- R6: In shared mode with no window open, `bus_req_i`=1 with `xfer_req_i`=1 gives a one-cycle pulse on `chan_req_o[2]` in the next cycle. No grant follows.
- R7: With `shared_mode_i`=0, `chan_req_o[0]` follows `bus_req_i` and `chan_req_o[1]` follows `xfer_req_i`, each one cycle later. No grant and no general request are produced.
- R8: An acknowledge for channel `ack_chan_i` gives `strobe_o`=1 together with `chan_id_o`=`ack_chan_i[1:0]` and `bavl_id2_o`=`ack_chan_i[2]`, all in the same cycle. That cycle is normally the one after the request. `chan_id_o` is zero whenever `strobe_o` is low.
- R9: `strobe_o` is never high in a grant cycle. An acknowledge that would fall on a grant cycle is issued one cycle later.
- R10: Acknowledges are issued one per cycle, in arrival order. Up to `ACK_QDEPTH` of them can wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shared_mode_i | input | 1 | 1 selects bus-sharing mode |
| bus_req_i | input | 1 | Bus request from the external device |
| xfer_req_i | input | 1 | Transfer request from the external device |
| bus_data_i | input | DESC_W | Data bus carrying the descriptor |
| ack_req_i | input | 1 | An engine asks for an acknowledge |
| ack_chan_i | input | $clog2(NCH) | Channel being acknowledged |
| bavl_id2_o | output | 1 | Shared pin: bus available, or the top channel-number bit |
| strobe_o | output | 1 | Acknowledge strobe |
| chan_id_o | output | $clog2(NCH)-1 | Low channel-number bits |
| gen_req_o | output | 1 | General DMA request pulse |
| chan_req_o | output | NCH | Per-channel request pulses |
| desc_o | output | DESC_W | Captured descriptor |
| desc_valid_o | output | 1 | One-cycle pulse when a new descriptor is captured |

## Verification
Grants are run with the strobe placed in the sample cycle, one cycle early, and missing. This tells correct window timing apart from an off-by-one and from capture with no strobe. Single-pin and dual-pin requests are applied both with a window open and with none, and in both modes. This separates the general request, the direct request to channel 2 and the plain channel 0/1 lines. Acknowledges are aimed at grant cycles, sent back to back, and use channels whose top bit is set. These patterns expose pin collisions, lost or reordered acknowledges and a wrong bit on the shared pin. A reset in the middle of a window shows that the partial window is discarded.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
   // Phases of the grant window; the sample phase is the second cycle after the grant
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_GRANT  = 2'd1,
      PH_WAIT   = 2'd2,
      PH_SAMPLE = 2'd3
   } phase_e;

   // Channel that receives a simultaneous two-pin request
   localparam int DIRECT_CH = 2;
   // Channels driven by the plain request pins when sharing is off
   localparam int PLAIN_CH_BUS  = 0;
   localparam int PLAIN_CH_XFER = 1;
endpackage

// File: rtl/xdma_window_fsm.sv
module xdma_window_fsm
   import xdma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic shared_i,
   input  logic bus_req_i,
   input  logic xfer_req_i,
   output logic grant_o,
   output logic grant_next_o,
   output logic sample_o,
   output logic idle_o
);
   phase_e ph_q, ph_d;

   assign idle_o       = (ph_q == PH_IDLE);
   assign grant_o      = (ph_q == PH_GRANT);
   assign sample_o     = (ph_q == PH_SAMPLE);
   assign grant_next_o = shared_i && idle_o && bus_req_i && !xfer_req_i;

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_IDLE:   if (grant_next_o) ph_d = PH_GRANT;
         PH_GRANT:  ph_d = PH_WAIT;
         PH_WAIT:   ph_d = PH_SAMPLE;
         default:   ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   // R2: the grant lasts a single cycle
   assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> !grant_o);
   // R2: a grant only follows a lone bus request in shared mode
   assert_grant_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_o) |-> $past(shared_i && bus_req_i && !xfer_req_i));
   // R3: the sample phase comes two cycles after the grant
   assert_sample_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> ##1 sample_o);
endmodule

// File: rtl/xdma_req_decode.sv
module xdma_req_decode
   import xdma_pkg::*;
#(
   parameter int NCH        = 8,
   parameter int DESC_W     = 32,
   parameter bit DESC_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shared_i,
   input  logic              idle_i,
   input  logic              sample_i,
   input  logic              bus_req_i,
   input  logic              xfer_req_i,
   input  logic [DESC_W-1:0] data_i,
   output logic              gen_req_o,
   output logic [NCH-1:0]    chan_req_o,
   output logic [DESC_W-1:0] desc_o,
   output logic              desc_valid_o
);
   logic [NCH-1:0] hit;
   logic           capture;
   logic           gen_hit;

   assign capture = sample_i && xfer_req_i;
   assign gen_hit = shared_i && idle_i && xfer_req_i && !bus_req_i;

   for (genvar c = 0; c < NCH; c++) begin : g_hit
      if (c == PLAIN_CH_BUS) begin : g_bus
         assign hit[c] = !shared_i && bus_req_i;
      end else if (c == PLAIN_CH_XFER) begin : g_xfer
         assign hit[c] = !shared_i && xfer_req_i;
      end else if (c == DIRECT_CH) begin : g_direct
         assign hit[c] = shared_i && idle_i && bus_req_i && xfer_req_i;
      end else begin : g_none
         assign hit[c] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_req_o   <= '0;
         gen_req_o    <= 1'b0;
         desc_valid_o <= 1'b0;
      end else begin
         chan_req_o   <= hit;
         gen_req_o    <= gen_hit;
         desc_valid_o <= capture;
      end
   end

   // Descriptor holding register: with or without reset
   if (DESC_RESET) begin : g_desc_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       desc_o <= '0;
         else if (capture) desc_o <= data_i;
      end
   end else begin : g_desc_norst
      always_ff @(posedge clk) begin
         if (capture) desc_o <= data_i;
      end
   end

   // R3: a valid pulse only after a strobe in the sample phase
   assert_desc_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid_o |-> $past(sample_i && xfer_req_i));
   // R4: the descriptor holds when nothing is captured
   assert_desc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_i && xfer_req_i) |=> $stable(desc_o));
   // R4: no shared-mode request pulses for inputs seen while a window is open
   assert_window_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shared_i && !idle_i) |=> (!gen_req_o && !chan_req_o[DIRECT_CH]));
   // R7: plain mode raises no general request
   assert_plain_no_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !shared_i |=> !gen_req_o);
endmodule

// File: rtl/xdma_ack_fifo.sv
module xdma_ack_fifo #(
   parameter int W     = 3,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] head_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xdma_ack_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign head_o  = mem[rd_q];

   function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= wrap_inc(wr_q);
         if (pop_i)  rd_q <= wrap_inc(rd_q);
         if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
         else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_q] <= din_i;
   end

   // R10: waiting acknowledges never exceed the queue depth
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o) |-> pop_i);
   // R10: nothing is taken from an empty queue
   assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
endmodule

// File: rtl/xdma_ack_mux.sv
module xdma_ack_mux #(
   parameter int ID_W   = 3,
   parameter int QDEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ack_req_i,
   input  logic [ID_W-1:0] ack_chan_i,
   input  logic            grant_i,
   input  logic            grant_next_i,
   output logic            bavl_id2_o,
   output logic            strobe_o,
   output logic [ID_W-2:0] chan_id_o
);
   logic            q_empty, q_full;
   logic [ID_W-1:0] q_head;
   logic            have, issue, pop, push;
   logic [ID_W-1:0] cand;
   logic            strobe_q;
   logic [ID_W-1:0] chan_q;

   assign have  = !q_empty || ack_req_i;
   assign cand  = q_empty ? ack_chan_i : q_head;
   assign issue = have && !grant_next_i;
   assign pop   = issue && !q_empty;
   assign push  = ack_req_i && !(issue && q_empty);

   xdma_ack_fifo #(.W(ID_W), .DEPTH(QDEPTH)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   (ack_chan_i),
      .pop_i   (pop),
      .head_o  (q_head),
      .empty_o (q_empty),
      .full_o  (q_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         chan_q   <= '0;
      end else begin
         strobe_q <= issue;
         if (issue) chan_q <= cand;
      end
   end

   assign strobe_o   = strobe_q;
   assign chan_id_o  = strobe_q ? chan_q[ID_W-2:0] : '0;
   assign bavl_id2_o = grant_i || (strobe_q && chan_q[ID_W-1]);

   // R9: grant and acknowledge never share the pin in one cycle
   assert_pin_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_i && strobe_o));
   // R8: every strobe has a pending or arriving acknowledge behind it
   assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(ack_req_i || !q_empty));
   // R9: an acknowledge held back by a grant goes out in the cycle after it
   assert_deferred_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_next_i && ack_req_i) |=> ##1 strobe_o);
   // R8: the low id lines are quiet without a strobe
   assert_id_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |-> (chan_id_o == '0));
   // R10: the pending queue itself never overflows
   assert_queue_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !(push && !pop));
endmodule

// File: rtl/xdma_handshake.sv
module xdma_handshake
   import xdma_pkg::*;
#(
   parameter int NCH        = 8,
   parameter int DESC_W     = 32,
   parameter int ACK_QDEPTH = 4,
   parameter bit DESC_RESET = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shared_mode_i,
   input  logic                     bus_req_i,
   input  logic                     xfer_req_i,
   input  logic [DESC_W-1:0]        bus_data_i,
   input  logic                     ack_req_i,
   input  logic [$clog2(NCH)-1:0]   ack_chan_i,
   output logic                     bavl_id2_o,
   output logic                     strobe_o,
   output logic [$clog2(NCH)-2:0]   chan_id_o,
   output logic                     gen_req_o,
   output logic [NCH-1:0]           chan_req_o,
   output logic [DESC_W-1:0]        desc_o,
   output logic                     desc_valid_o
);
   localparam int ID_W = $clog2(NCH);

   if (NCH <= DIRECT_CH) begin : g_bad_nch
      $error("xdma_handshake: NCH must include the direct-request channel");
   end
   if (DESC_W < 1) begin : g_bad_desc
      $error("xdma_handshake: DESC_W must be positive");
   end

   logic grant, grant_next, sample, idle;

   xdma_window_fsm u_window (
      .clk          (clk),
      .rst_n        (rst_n),
      .shared_i     (shared_mode_i),
      .bus_req_i    (bus_req_i),
      .xfer_req_i   (xfer_req_i),
      .grant_o      (grant),
      .grant_next_o (grant_next),
      .sample_o     (sample),
      .idle_o       (idle)
   );

   xdma_req_decode #(.NCH(NCH), .DESC_W(DESC_W), .DESC_RESET(DESC_RESET)) u_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .shared_i     (shared_mode_i),
      .idle_i       (idle),
      .sample_i     (sample),
      .bus_req_i    (bus_req_i),
      .xfer_req_i   (xfer_req_i),
      .data_i       (bus_data_i),
      .gen_req_o    (gen_req_o),
      .chan_req_o   (chan_req_o),
      .desc_o       (desc_o),
      .desc_valid_o (desc_valid_o)
   );

   xdma_ack_mux #(.ID_W(ID_W), .QDEPTH(ACK_QDEPTH)) u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .ack_req_i    (ack_req_i),
      .ack_chan_i   (ack_chan_i),
      .grant_i      (grant),
      .grant_next_i (grant_next),
      .bavl_id2_o   (bavl_id2_o),
      .strobe_o     (strobe_o),
      .chan_id_o    (chan_id_o)
   );

   // R6: a direct request never starts a grant
   assert_direct_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_req_o[DIRECT_CH] |-> !grant);
endmodule

// File: tb/xdma_handshake_tb.sv
`timescale 1ns/1ps
module xdma_handshake_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sh = 1'b0, b = 1'b0, t = 1'b0, ack = 1'b0;
   logic [31:0] data = '0;
   logic [2:0]  achan = '0;

   logic        pin, strobe, gen, dv;
   logic [1:0]  cid;
   logic [7:0]  creq;
   logic [31:0] desc;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xdma_handshake u_dut (
      .clk(clk), .rst_n(rst_n), .shared_mode_i(sh), .bus_req_i(b), .xfer_req_i(t),
      .bus_data_i(data), .ack_req_i(ack), .ack_chan_i(achan),
      .bavl_id2_o(pin), .strobe_o(strobe), .chan_id_o(cid), .gen_req_o(gen),
      .chan_req_o(creq), .desc_o(desc), .desc_valid_o(dv)
   );

   // Behavioural reference model
   int          m_phase = 0;
   bit          m_strobe = 0;
   int          m_chan = 0;
   bit          m_gen = 0;
   bit [7:0]    m_req = '0;
   bit          m_dv = 0;
   logic [31:0] m_desc = '0;
   int          q[$];

   always @(posedge clk) begin
      int old;
      bit gn;
      old = m_phase;
      if (!rst_n) begin
         m_phase = 0; m_strobe = 0; m_chan = 0; m_gen = 0;
         m_req = '0; m_dv = 0; m_desc = '0; q.delete();
      end else begin
         gn = sh && old == 0 && b && !t;
         if ((q.size() > 0 || ack) && !gn) begin
            m_strobe = 1;
            if (q.size() > 0) begin
               m_chan = q.pop_front();
               if (ack) q.push_back(int'(achan));
            end else m_chan = int'(achan);
         end else begin
            m_strobe = 0;
            if (ack) q.push_back(int'(achan));
         end
         m_req = '0;
         if (!sh) begin m_req[0] = b; m_req[1] = t; end
         else if (old == 0 && b && t) m_req[2] = 1;
         m_gen = sh && old == 0 && t && !b;
         m_dv = (old == 3) && t;
         if (m_dv) m_desc = data;
         if (old == 0) m_phase = gn ? 1 : 0;
         else m_phase = (old + 1) % 4;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         bit ep;
         ep = (m_phase == 1) || (m_strobe && m_chan[2]);
         chk(rst_n ? "R2/R9 shared pin" : "R1 shared pin", 64'(pin), 64'(ep));
         chk(rst_n ? "R8/R9 strobe" : "R1 strobe", 64'(strobe), 64'(m_strobe));
         chk(rst_n ? "R8/R10 chan_id" : "R1 chan_id", 64'(cid), m_strobe ? 64'(m_chan[1:0]) : 64'd0);
         chk(rst_n ? "R5 gen_req" : "R1 gen_req", 64'(gen), 64'(m_gen));
         chk(rst_n ? (sh ? "R6 chan_req" : "R7 chan_req") : "R1 chan_req", 64'(creq), 64'(m_req));
         chk(rst_n ? "R3 desc_valid" : "R1 desc_valid", 64'(dv), 64'(m_dv));
         chk(rst_n ? "R4 desc" : "R1 desc", 64'(desc), 64'(m_desc));
      end
   end

   task automatic step(input bit s, input bit bb, input bit tt, input logic [31:0] d,
                       input bit a, input int c);
      @(negedge clk);
      #0.5;
      sh = s; b = bb; t = tt; data = d;
      ack = a && (q.size() < 2);
      achan = c[2:0];
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(sh, 0, 0, 32'h0, 0, 0);
   endtask

   task automatic report;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #0.5 rst_n = 1'b1;
      idle(2);
      // R2/R3: grant then descriptor in the sample cycle
      step(1, 1, 0, 32'h0, 0, 0);
      step(1, 0, 0, 32'h0, 0, 0);
      step(1, 0, 0, 32'h0, 0, 0);
      step(1, 0, 1, 32'hCAFE_0123, 0, 0);
      idle(3);
      // R4: strobe one cycle early, missing in the sample cycle, noise in window
      step(1, 1, 0, 32'h0, 0, 0);
      step(1, 1, 1, 32'h0, 0, 0);
      step(1, 0, 1, 32'h1111_2222, 0, 0);
      step(1, 0, 0, 32'h3333_4444, 0, 0);
      idle(3);
      // R5 / R6: requests with no window open
      step(1, 0, 1, 32'h0, 0, 0);
      idle(1);
      step(1, 1, 1, 32'h0, 0, 0);
      idle(3);
      // R7: plain mode
      step(0, 1, 0, 32'h0, 0, 0);
      step(0, 0, 1, 32'h0, 0, 0);
      step(0, 1, 1, 32'h0, 0, 0);
      step(0, 0, 0, 32'h0, 0, 0);
      // R8: acknowledge with top bit clear and set
      step(1, 0, 0, 32'h0, 1, 3);
      step(1, 0, 0, 32'h0, 1, 6);
      idle(3);
      // R9/R10: acknowledge colliding with a grant, then back to back
      step(1, 1, 0, 32'h0, 1, 5);
      step(1, 0, 0, 32'h0, 1, 7);
      step(1, 0, 0, 32'h0, 1, 2);
      step(1, 0, 1, 32'hA5A5_5A5A, 0, 0);
      idle(4);
      // R1: reset in the middle of a window
      step(1, 1, 0, 32'h0, 1, 4);
      step(1, 0, 0, 32'h0, 0, 0);
      @(negedge clk); #0.4 rst_n = 1'b0;
      step(1, 0, 1, 32'hDEAD_BEEF, 0, 0);
      step(1, 0, 0, 32'h0, 0, 0);
      @(negedge clk); #0.4 rst_n = 1'b1;
      step(1, 0, 1, 32'h0BAD_F00D, 0, 0);
      idle(3);
      // Mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         step((r < 95) ? 1 : 0, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
              $urandom, ($urandom_range(0, 9) < 4), $urandom_range(0, 7));
      end
      idle(4);
      report();
   end
endmodule